// File: doc/BRIEF.md
# Dual-Mode Decrementer Timer

A down-counting timer register for a processor core. Software loads a count through a write port and reads the live count back. The count drops by one on every cycle in which the tick enable is high, so the tick enable sets the rate. An interrupt request is raised according to one of two trigger modes.

In sign-edge mode, the request is raised on the tick that moves the count from zero to all-ones, which is the point where the count turns negative. The counter then keeps counting down with no limit. In zero-stop mode, the request is raised on the tick that brings the count to zero, and the counter then stays at zero.

In both modes the edge request is a sticky pending bit, and an acknowledge input clears it. A separate level option drives the interrupt output straight from the top bit of the count instead of from the pending bit. The trigger mode and the level option are held in a small configuration register, which is loaded through a strobe.

Top module: `downcount_alarm`

## Requirements
- R1: After reset the count is zero, no request is pending, the block is in zero-stop mode and the level option is off, so `rd_data` is 0 and `irq` is 0.
- R2: When `wr_en` is high, the count takes `wr_data` at that clock edge, and a decrement on the same edge is ignored. The new value is on `rd_data` from the next cycle.
- R3: In sign-edge mode (`cfg_sign`=1), every tick without a write lowers the count by one modulo 2^WIDTH. Counting carries on through negative values.
- R4: In sign-edge mode, a tick when the count is zero sets the pending bit. In edge output mode, `irq` is high from the next cycle.
- R5: In zero-stop mode (`cfg_sign`=0), a tick at count 1 sets the pending bit. A tick at count 0 leaves the count at 0 and does not set the pending bit.
- R6: In zero-stop mode, writing 0 leaves the counter stopped with no new request. Writing a non-zero value starts counting again.
- R7: A write never sets the pending bit, even when the written value has its top bit set and the old value did not.
- R8: `irq_ack` clears the pending bit. If a trigger and an acknowledge fall in the same cycle, the pending bit ends up set.
- R9: With the level option on (`cfg_level`=1), `irq` equals bit WIDTH-1 of the count, whatever the state of the pending bit.
- R10: A cycle with neither a write nor a tick leaves the count unchanged.
- R11: A pulse on `cfg_wr` loads `cfg_sign` and `cfg_level`. The new mode governs ticks from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Decrement enable, one step per high cycle |
| wr_en | input | 1 | Load the count from wr_data |
| wr_data | input | WIDTH | Value to load |
| rd_data | output | WIDTH | Current count |
| cfg_wr | input | 1 | Load the configuration register |
| cfg_sign | input | 1 | 1 = sign-edge mode, 0 = zero-stop mode |
| cfg_level | input | 1 | 1 = irq follows the top bit of the count |
| irq_ack | input | 1 | Clear the pending request |
| irq | output | 1 | Interrupt request |

## Verification
For each mode, the bench loads every value of an 8-bit counter and applies a single tick. This sweep separates the wrap at zero (sign-edge: count becomes all-ones and the request fires) from the hold at zero (zero-stop: count stays, no request). It also shows that the request fires only at zero or one and at no other value. Directed sequences cover the remaining cases: a write colliding with a tick, a write that sets the top bit, a trigger colliding with an acknowledge, stopping and restarting in zero-stop mode, the level output following the sign bit, and idle cycles leaving the count alone.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef enum logic {
    TRIG_ZERO_STOP = 1'b0,
    TRIG_SIGN_EDGE = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/dca_next.sv
// Next-count and trigger-event logic for the decrementer.
module dca_next
  import dca_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cnt,
  input  trig_mode_e       mode,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] cnt_n,
  output logic             fire
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] dec;
  assign dec = cnt - ONE;

  always_comb begin
    cnt_n = cnt;
    fire  = 1'b0;
    if (wr_en) begin
      cnt_n = wr_data;                 // software load wins, never fires
    end else if (tick_en) begin
      case (mode)
        TRIG_SIGN_EDGE: begin
          cnt_n = dec;
          fire  = ~cnt[WIDTH-1] & dec[WIDTH-1];
        end
        default: begin
          if (cnt != ZERO) begin
            cnt_n = dec;
            fire  = (dec == ZERO);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dca_pending.sv
// Sticky pending request: set by a trigger, cleared by acknowledge.
module dca_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic pend_q
);
  logic pend_n;

  always_comb begin
    pend_n = pend_q;
    if (ack)  pend_n = 1'b0;
    if (fire) pend_n = 1'b1;           // trigger has priority over ack
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end
endmodule

// File: rtl/downcount_alarm.sv
module downcount_alarm
  import dca_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic             cfg_wr,
  input  logic             cfg_sign,
  input  logic             cfg_level,
  input  logic             irq_ack,
  output logic             irq
);
  localparam int MSB = WIDTH - 1;

  trig_mode_e       mode_q, mode_n;
  logic             level_q, level_n;
  logic [WIDTH-1:0] cnt_q, cnt_n;
  logic             fire;
  logic             pend_q;

  // configuration register
  always_comb begin
    mode_n  = mode_q;
    level_n = level_q;
    if (cfg_wr) begin
      mode_n  = cfg_sign ? TRIG_SIGN_EDGE : TRIG_ZERO_STOP;
      level_n = cfg_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= TRIG_ZERO_STOP;
      level_q <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      level_q <= level_n;
    end
  end

  dca_next #(.WIDTH(WIDTH)) u_next (
    .cnt     (cnt_q),
    .mode    (mode_q),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cnt_n   (cnt_n),
    .fire    (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  dca_pending u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .ack    (irq_ack),
    .pend_q (pend_q)
  );

  assign rd_data = cnt_q;
  assign irq     = level_q ? cnt_q[MSB] : pend_q;
endmodule

// File: rtl/dca_checker.sv
module dca_checker
  import dca_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             irq_ack,
  input logic [WIDTH-1:0] cnt_q,
  input trig_mode_e       mode_q,
  input logic             pend_q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_data));

  p_sign_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick_en && mode_q == TRIG_SIGN_EDGE) |=> cnt_q == $past(cnt_q) - ONE);

  p_sign_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick_en && mode_q == TRIG_SIGN_EDGE && cnt_q == '0) |=> pend_q);

  p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode_q == TRIG_ZERO_STOP && cnt_q == '0) |=> cnt_q == '0);

  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pend_q) |=> !pend_q);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && (wr_en || !tick_en)) |=> !pend_q);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick_en) |=> $stable(cnt_q));
endmodule

bind downcount_alarm dca_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .irq_ack (irq_ack),
  .cnt_q   (cnt_q),
  .mode_q  (mode_q),
  .pend_q  (pend_q)
);

// File: tb/sim_downcount_alarm.sv
`timescale 1ns/1ps
module sim_downcount_alarm;
  localparam int W = 8;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b0, wr_en = 1'b0, cfg_wr = 1'b0;
  logic         cfg_sign = 1'b0, cfg_level = 1'b0, irq_ack = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         irq;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  downcount_alarm #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cfg_wr(cfg_wr),
    .cfg_sign(cfg_sign), .cfg_level(cfg_level), .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge, then release all strobes; outputs sampled 1 ns after edge
  task automatic step();
    @(posedge clk); #1;
    tick_en = 0; wr_en = 0; cfg_wr = 0; irq_ack = 0;
  endtask

  task automatic set_cfg(input logic s, input logic l);
    cfg_wr = 1; cfg_sign = s; cfg_level = l; step();
  endtask

  task automatic load(input int v, input logic ack);
    wr_en = 1; wr_data = W'(v); irq_ack = ack; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", int'(rd_data), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1;
    // R1: reset mode is zero-stop, so a tick at zero neither wraps nor fires
    tick_en = 1; step();
    chk("R1 zero-stop default count", int'(rd_data), 0);
    chk("R1 zero-stop default irq", int'(irq), 0);

    // R3/R4 sweep in sign-edge mode
    set_cfg(1, 0);
    for (int v = 0; v < N; v++) begin
      load(v, 1);
      chk("R2 load", int'(rd_data), v);
      tick_en = 1; step();
      chk("R3 dec", int'(rd_data), (v + N - 1) % N);
      chk("R4 fire", int'(irq), (v == 0) ? 1 : 0);
    end

    // R5 sweep in zero-stop mode
    set_cfg(0, 0);
    for (int v = 0; v < N; v++) begin
      load(v, 1);
      tick_en = 1; step();
      chk("R5 count", int'(rd_data), (v == 0) ? 0 : v - 1);
      chk("R5 fire", int'(irq), (v == 1) ? 1 : 0);
    end

    // R6: stopped at zero, write zero stays stopped, nonzero restarts
    load(0, 1);
    tick_en = 1; step(); tick_en = 1; step();
    chk("R6 zero stays", int'(rd_data), 0);
    chk("R6 no request", int'(irq), 0);
    load(3, 0);
    repeat (3) begin tick_en = 1; step(); end
    chk("R6 restart count", int'(rd_data), 0);
    chk("R6 restart fire", int'(irq), 1);

    // R8: ack clears; trigger beats same-cycle ack
    irq_ack = 1; step();
    chk("R8 ack clears", int'(irq), 0);
    load(1, 0);
    tick_en = 1; irq_ack = 1; step();
    chk("R8 trigger wins", int'(irq), 1);
    irq_ack = 1; step();

    // R2: write collides with tick
    set_cfg(1, 0);
    load(20, 0);
    wr_en = 1; wr_data = 8'd50; tick_en = 1; step();
    chk("R2 write beats tick", int'(rd_data), 50);

    // R7: write sets sign bit, no request
    load(5, 1);
    load(8'h90, 0);
    chk("R7 no fire on write", int'(irq), 0);
    tick_en = 1; step();
    chk("R3 keeps going negative", int'(rd_data), 8'h8F);
    chk("R7 still quiet", int'(irq), 0);

    // R10: idle holds
    repeat (4) step();
    chk("R10 hold", int'(rd_data), 8'h8F);

    // R9: level follows top bit, independent of pending
    set_cfg(1, 1);
    chk("R9 level high", int'(irq), 1);
    load(8'h7F, 0);
    chk("R9 level low", int'(irq), 0);
    load(0, 0);
    tick_en = 1; step();
    chk("R9 level after wrap", int'(irq), 1);
    irq_ack = 1; step();
    chk("R9 ignores ack", int'(irq), 1);

    // R11: mode change governs ticks from next cycle
    set_cfg(0, 0);
    load(0, 1);
    tick_en = 1; step();
    chk("R11 zero-stop took effect", int'(rd_data), 0);
    cfg_wr = 1; cfg_sign = 1; cfg_level = 0; tick_en = 1; step();
    chk("R11 same-cycle tick uses old mode", int'(rd_data), 0);
    tick_en = 1; step();
    chk("R11 new mode wraps", int'(rd_data), N - 1);
    chk("R11 new mode fires", int'(irq), 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule